// File: doc/BRIEF.md
# Event ID Matching Controller

This block keeps readout channels in step with a trigger source. A small FIFO collects 36-bit event IDs from the trigger side. The controller takes the oldest one as the current event and sends request strobes for it, spaced by a programmable interval. It keeps doing so until every enabled channel has returned a reply that carries that ID. Then it takes the next event. Each time a new event becomes current, a 4-bit request ID advances, so requests for different events can be told apart. A retry counter shows how many requests the current event has needed.

An operator can park the controller with a halt control. Halt is set after reset. While halted the controller sends no requests and does not advance on its own. A force strobe, accepted only while halted, pushes the current event out unmatched and loads the next one. Each channel has an enable bit and a matched flag. A disabled channel never holds up an event. The transmit link and the decoding of replies lie outside the block. Replies arrive here as (channel, event ID) strobes.

Top module: `evid_match_ctrl`

## Requirements
- R1: After reset: `halted`=1, `fifo_count`=0, `cur_valid`=0, `rqid`=0, `retry_cnt`=0, `ivl`=0x07FF, every `chan_en` bit is 1, every `chan_matched` bit is 0, and `req_valid`=0.
- R2: A `trig_valid` strobe stores `trig_evid` in the FIFO, which holds 8 entries, and always updates `newest_evid`. A strobe that arrives while 8 IDs are stored is dropped. `fifo_count` counts the stored IDs and never includes the current event.
- R3: While `halted`=1, `req_valid` stays 0 and the current event does not change, except through the force strobe.
- R4: A `force_adv` strobe while halted makes the FIFO head current at the next edge. If the FIFO is empty, it leaves no current event. A strobe while not halted has no effect.
- R5: Each time an event becomes current, `rqid` increments by 1 modulo 16, `retry_cnt` clears to 0, all `chan_matched` bits clear, and `fifo_count` drops by 1. When running with no current event and a non-empty FIFO, the head is loaded at the next edge.
- R6: `req_valid` is high for one cycle in the first cycle an event is current and not halted. After that it rises once every `ivl` cycles (every cycle when `ivl` is 0 or 1) and carries `cur_evid` and `rqid`. Each request adds 1 to `retry_cnt` at the following edge.
- R7: A reply with `rsp_valid`=1 sets `chan_matched[rsp_chan]` only when `rsp_evid` equals the current ID. A reply with any other ID changes nothing.
- R8: Once every enabled channel is matched (a channel with `chan_en` bit 0 counts as matched), no further request is sent. The next ID becomes current at the next edge, or `cur_valid` falls if the FIFO is empty.
- R9: Writes through `cfg_ivl_we`, `cfg_halt_we` and `cfg_en_we` take effect from the next edge. A new interval applies from the next timer reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Event ID strobe from trigger side |
| trig_evid | input | 36 | Event ID to queue |
| cfg_halt_we | input | 1 | Write enable for halt |
| cfg_halt_d | input | 1 | New halt value |
| cfg_ivl_we | input | 1 | Write enable for re-request interval |
| cfg_ivl_d | input | 16 | New interval in cycles |
| cfg_en_we | input | 1 | Write enable for channel enables |
| cfg_en_d | input | 4 | New channel enable mask |
| force_adv | input | 1 | Force current event out (halted only) |
| rsp_valid | input | 1 | Channel reply strobe |
| rsp_chan | input | 2 | Replying channel |
| rsp_evid | input | 36 | Event ID in the reply |
| req_valid | output | 1 | Request strobe to all channels |
| req_evid | output | 36 | Event ID being requested |
| req_rqid | output | 4 | Request ID sent with the request |
| halted | output | 1 | Halt state |
| fifo_count | output | 4 | Queued IDs, excluding the current one |
| cur_valid | output | 1 | A current event exists |
| cur_evid | output | 36 | Current event ID |
| newest_evid | output | 36 | Last ID received from trigger side |
| rqid | output | 4 | Current request ID |
| retry_cnt | output | 16 | Requests sent for current event |
| ivl | output | 16 | Re-request interval |
| chan_en | output | 4 | Channel enable mask |
| chan_matched | output | 4 | Per-channel matched flags |

## Verification
Matching is tried with four reply patterns. A reply carrying a wrong ID must leave the flags clear. Replies from all four channels one by one must complete the event only on the last one. With two channels disabled, two replies must be enough. With all channels disabled, the event must complete at once with no reply at all. Request timing is checked against an interval of 4, which shows the gap of three quiet cycles, and against an interval of 0, which shows back-to-back requests with the retry count climbing by one. A run of nine IDs into a halted block, drained by force strobes, shows the FIFO order, the drop when full and the request ID sequence. A force strobe while running shows that it is ignored.

// File: rtl/evid_pkg.sv
package evid_pkg;
  typedef enum logic {ST_EMPTY = 1'b0, ST_HUNT = 1'b1} mstate_e;
  localparam int unsigned EVID_W_DEF = 36;
  localparam logic [15:0] IVL_RST_DEF = 16'h07FF;
endpackage

// File: rtl/evid_rst_sync.sv
module evid_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/evid_fifo.sv
module evid_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 36,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_q];
  assign count   = cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push_ok ? bump(wr_q) : wr_q;
    rd_d  = pop_ok  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/evid_req_timer.sv
module evid_req_timer #(
  parameter int unsigned TMR_W  = 16,
  parameter int unsigned RTRY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fire,
  input  logic              run,
  input  logic [TMR_W-1:0]  ivl,
  output logic              tmr_zero,
  output logic [RTRY_W-1:0] retry
);
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [RTRY_W-1:0] rty_q, rty_d;
  logic              tmr_en, rty_en;

  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    tmr_en = 1'b0;
    tmr_d  = tmr_q;
    if (clr) begin
      tmr_en = 1'b1;
      tmr_d  = '0;
    end else if (fire) begin
      tmr_en = 1'b1;
      tmr_d  = (ivl == '0) ? '0 : ivl - 1'b1;
    end else if (run && !tmr_zero) begin
      tmr_en = 1'b1;
      tmr_d  = tmr_q - 1'b1;
    end
    rty_en = clr || fire;
    rty_d  = clr ? '0 : rty_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      rty_q <= '0;
    end else begin
      if (tmr_en) tmr_q <= tmr_d;
      if (rty_en) rty_q <= rty_d;
    end
  end

  assign retry = rty_q;
endmodule

// File: rtl/evid_chan_track.sv
module evid_chan_track #(
  parameter int unsigned NCH   = 4,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            hit,
  input  logic [CH_W-1:0] hit_chan,
  input  logic            en_we,
  input  logic [NCH-1:0]  en_d,
  output logic [NCH-1:0]  en,
  output logic [NCH-1:0]  matched,
  output logic            all_done
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic en_q, mt_q, mt_d, mt_en, sel;
    assign sel = hit && (hit_chan == CH_W'(i));
    always_comb begin
      mt_en = clr || sel;
      mt_d  = !clr;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b1;
        mt_q <= 1'b0;
      end else begin
        if (en_we) en_q <= en_d[i];
        if (mt_en) mt_q <= mt_d;
      end
    end
    assign en[i]      = en_q;
    assign matched[i] = mt_q;
  end

  assign all_done = &(matched | ~en);
endmodule

// File: rtl/evid_match_ctrl.sv
module evid_match_ctrl
  import evid_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter int unsigned ID_W       = EVID_W_DEF,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned RQ_W       = 4,
  parameter int unsigned TMR_W      = 16,
  parameter int unsigned RTRY_W     = 16,
  parameter logic [TMR_W-1:0] IVL_RST = TMR_W'(IVL_RST_DEF),
  localparam int unsigned CH_W      = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned FCNT_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [ID_W-1:0]   trig_evid,
  input  logic              cfg_halt_we,
  input  logic              cfg_halt_d,
  input  logic              cfg_ivl_we,
  input  logic [TMR_W-1:0]  cfg_ivl_d,
  input  logic              cfg_en_we,
  input  logic [NCH-1:0]    cfg_en_d,
  input  logic              force_adv,
  input  logic              rsp_valid,
  input  logic [CH_W-1:0]   rsp_chan,
  input  logic [ID_W-1:0]   rsp_evid,
  output logic              req_valid,
  output logic [ID_W-1:0]   req_evid,
  output logic [RQ_W-1:0]   req_rqid,
  output logic              halted,
  output logic [FCNT_W-1:0] fifo_count,
  output logic              cur_valid,
  output logic [ID_W-1:0]   cur_evid,
  output logic [ID_W-1:0]   newest_evid,
  output logic [RQ_W-1:0]   rqid,
  output logic [RTRY_W-1:0] retry_cnt,
  output logic [TMR_W-1:0]  ivl,
  output logic [NCH-1:0]    chan_en,
  output logic [NCH-1:0]    chan_matched
);
  logic             rst_i_n;
  mstate_e          state_q, state_d;
  logic             halt_q;
  logic [TMR_W-1:0] ivl_q;
  logic [ID_W-1:0]  cur_q, new_q;
  logic [RQ_W-1:0]  rqid_q;
  logic [ID_W-1:0]  fifo_head;
  logic             fifo_empty;
  logic             go, done, take, pop, fire, tmr_zero, hit;

  evid_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  evid_fifo #(.DEPTH(FIFO_DEPTH), .DW(ID_W)) i_fifo (
    .clk(clk), .rst_n(rst_i_n), .push(trig_valid), .push_data(trig_evid),
    .pop(pop), .head(fifo_head), .empty(fifo_empty), .count(fifo_count)
  );

  evid_req_timer #(.TMR_W(TMR_W), .RTRY_W(RTRY_W)) i_tmr (
    .clk(clk), .rst_n(rst_i_n), .clr(pop), .fire(fire), .run(go),
    .ivl(ivl_q), .tmr_zero(tmr_zero), .retry(retry_cnt)
  );

  evid_chan_track #(.NCH(NCH)) i_trk (
    .clk(clk), .rst_n(rst_i_n), .clr(take), .hit(hit), .hit_chan(rsp_chan),
    .en_we(cfg_en_we), .en_d(cfg_en_d), .en(chan_en),
    .matched(chan_matched), .all_done(done)
  );

  // Control decisions
  always_comb begin
    go   = !halt_q;
    take = ((state_q == ST_EMPTY) && go && !fifo_empty) ||
           ((state_q == ST_HUNT)  && go && done) ||
           (halt_q && force_adv);
    pop  = take && !fifo_empty;
    fire = (state_q == ST_HUNT) && go && !done && tmr_zero;
    hit  = rsp_valid && (state_q == ST_HUNT) && (rsp_evid == cur_q);
  end

  // Next state
  always_comb begin
    state_d = state_q;
    if (take) state_d = fifo_empty ? ST_EMPTY : ST_HUNT;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_EMPTY;
      halt_q  <= 1'b1;
      ivl_q   <= IVL_RST;
      cur_q   <= '0;
      new_q   <= '0;
      rqid_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cfg_halt_we) halt_q <= cfg_halt_d;
      if (cfg_ivl_we)  ivl_q  <= cfg_ivl_d;
      if (trig_valid)  new_q  <= trig_evid;
      if (pop) begin
        cur_q  <= fifo_head;
        rqid_q <= rqid_q + 1'b1;
      end
    end
  end

  assign req_valid   = fire;
  assign req_evid    = cur_q;
  assign req_rqid    = rqid_q;
  assign halted      = halt_q;
  assign cur_valid   = (state_q == ST_HUNT);
  assign cur_evid    = cur_q;
  assign newest_evid = new_q;
  assign rqid        = rqid_q;
  assign ivl         = ivl_q;
endmodule

// File: rtl/evid_match_chk.sv
module evid_match_chk #(
  parameter int unsigned NCH        = 4,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned RQ_W       = 4,
  parameter int unsigned TMR_W      = 16,
  parameter int unsigned RTRY_W     = 16,
  localparam int unsigned FCNT_W    = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              halted,
  input logic [FCNT_W-1:0] fifo_count,
  input logic              cur_valid,
  input logic [RQ_W-1:0]   rqid,
  input logic [RTRY_W-1:0] retry_cnt,
  input logic [TMR_W-1:0]  ivl,
  input logic [NCH-1:0]    chan_en,
  input logic [NCH-1:0]    chan_matched
);
  // R3
  halt_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !req_valid);

  // R6
  retry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (retry_cnt == RTRY_W'($past(retry_cnt) + 1'b1)));

  // R6
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (ivl > TMR_W'(1))) |=> !req_valid);

  // R8
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid && (&(chan_matched | ~chan_en))) |-> !req_valid);

  // R5
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rqid != $past(rqid)) |-> ((chan_matched == '0) && (retry_cnt == '0)));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= FCNT_W'(FIFO_DEPTH));
endmodule

bind evid_match_ctrl evid_match_chk #(
  .NCH(NCH), .FIFO_DEPTH(FIFO_DEPTH), .RQ_W(RQ_W), .TMR_W(TMR_W), .RTRY_W(RTRY_W)
) i_evid_match_chk (.*);

// File: tb/test_evid_match_ctrl.sv
`timescale 1ns/1ps
module test_evid_match_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_valid, cfg_halt_we, cfg_halt_d, cfg_ivl_we, cfg_en_we;
  logic        force_adv, rsp_valid;
  logic [35:0] trig_evid, rsp_evid;
  logic [15:0] cfg_ivl_d;
  logic [3:0]  cfg_en_d;
  logic [1:0]  rsp_chan;
  logic        req_valid, halted, cur_valid;
  logic [35:0] req_evid, cur_evid, newest_evid;
  logic [3:0]  req_rqid, fifo_count, rqid, chan_en, chan_matched;
  logic [15:0] retry_cnt, ivl;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [3:0]  exp_rq = 4'd0;
  logic [35:0] ids [9];

  always #(CLK_PERIOD/2) clk = ~clk;

  evid_match_ctrl i_evid_match_ctrl (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      n_chk  = n_chk + 1;
      $display("FAIL watchdog: act=%0d expected below 20000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [35:0] id);
    trig_valid = 1'b1; trig_evid = id; tick(); trig_valid = 1'b0;
  endtask

  task automatic force_once();
    force_adv = 1'b1; tick(); force_adv = 1'b0;
  endtask

  task automatic reply(input logic [1:0] ch, input logic [35:0] id);
    rsp_valid = 1'b1; rsp_chan = ch; rsp_evid = id; tick(); rsp_valid = 1'b0;
  endtask

  task automatic set_halt(input logic v);
    cfg_halt_we = 1'b1; cfg_halt_d = v; tick(); cfg_halt_we = 1'b0;
  endtask

  task automatic set_ivl(input logic [15:0] v);
    cfg_ivl_we = 1'b1; cfg_ivl_d = v; tick(); cfg_ivl_we = 1'b0;
  endtask

  task automatic set_en(input logic [3:0] v);
    cfg_en_we = 1'b1; cfg_en_d = v; tick(); cfg_en_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "halted", halted, 1);
    chk("R1", "fifo_count", fifo_count, 0);
    chk("R1", "cur_valid", cur_valid, 0);
    chk("R1", "rqid", rqid, 0);
    chk("R1", "retry", retry_cnt, 0);
    chk("R1", "ivl", ivl, 16'h07FF);
    chk("R1", "chan_en", chan_en, 4'hF);
    chk("R1", "matched", chan_matched, 0);
    chk("R1", "req_valid", req_valid, 0);
  endtask

  task automatic t_fill_halted();
    push(ids[0]); push(ids[1]); push(ids[2]);
    chk("R2", "count after 3", fifo_count, 3);
    chk("R2", "newest", newest_evid, ids[2]);
    chk("R3", "no load while halted", cur_valid, 0);
    for (int k = 0; k < 5; k++) begin
      chk("R3", "no req while halted", req_valid, 0);
      tick();
    end
    chk("R3", "still no current", cur_valid, 0);
  endtask

  task automatic t_force_halted();
    force_once();
    exp_rq = exp_rq + 1'b1;
    chk("R4", "cur after force", cur_evid, ids[0]);
    chk("R4", "cur_valid", cur_valid, 1);
    chk("R5", "rqid", rqid, exp_rq);
    chk("R5", "count", fifo_count, 2);
    chk("R5", "retry", retry_cnt, 0);
    for (int k = 0; k < 4; k++) begin
      chk("R3", "no req halted with current", req_valid, 0);
      tick();
    end
    chk("R3", "cur held", cur_evid, ids[0]);
  endtask

  task automatic t_run_match();
    set_ivl(16'd4);
    chk("R9", "ivl write", ivl, 4);
    set_halt(1'b0);
    chk("R6", "first req", req_valid, 1);
    chk("R6", "req evid", req_evid, ids[0]);
    chk("R6", "req rqid", req_rqid, exp_rq);
    chk("R6", "retry before", retry_cnt, 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6", "gap quiet", req_valid, 0);
    end
    tick();
    chk("R6", "second req", req_valid, 1);
    chk("R6", "retry after first", retry_cnt, 1);
    reply(2'd0, ids[1]);
    chk("R7", "wrong id ignored", chan_matched, 0);
    reply(2'd0, ids[0]);
    chk("R7", "ch0 matched", chan_matched, 4'b0001);
    reply(2'd1, ids[0]);
    reply(2'd2, ids[0]);
    chk("R8", "not done at 3 of 4", cur_evid, ids[0]);
    reply(2'd3, ids[0]);
    chk("R7", "all matched", chan_matched, 4'hF);
    chk("R8", "no req when done", req_valid, 0);
    tick();
    exp_rq = exp_rq + 1'b1;
    chk("R8", "advanced", cur_evid, ids[1]);
    chk("R5", "rqid step", rqid, exp_rq);
    chk("R5", "matched cleared", chan_matched, 0);
    chk("R5", "count", fifo_count, 1);
  endtask

  task automatic t_disabled();
    set_en(4'b1001);
    reply(2'd0, ids[1]);
    chk("R8", "wait ch3", cur_evid, ids[1]);
    reply(2'd3, ids[1]);
    chk("R8", "done with disabled", chan_matched, 4'b1001);
    tick();
    exp_rq = exp_rq + 1'b1;
    chk("R8", "advanced disabled", cur_evid, ids[2]);
    chk("R5", "rqid", rqid, exp_rq);
    chk("R5", "count zero", fifo_count, 0);
  endtask

  task automatic t_force_running();
    force_once();
    chk("R4", "force ignored cur", cur_evid, ids[2]);
    chk("R4", "force ignored rqid", rqid, exp_rq);
    chk("R4", "still valid", cur_valid, 1);
  endtask

  task automatic t_all_disabled();
    set_en(4'b0000);
    chk("R8", "no req all disabled", req_valid, 0);
    tick();
    chk("R8", "empty after done", cur_valid, 0);
    chk("R8", "rqid unchanged", rqid, exp_rq);
  endtask

  task automatic t_ivl_zero();
    set_ivl(16'd0);
    set_en(4'hF);
    push(ids[3]);
    chk("R5", "queued", fifo_count, 1);
    tick();
    exp_rq = exp_rq + 1'b1;
    chk("R5", "auto load", cur_evid, ids[3]);
    chk("R5", "rqid", rqid, exp_rq);
    for (int k = 0; k < 3; k++) begin
      chk("R9", "req every cycle", req_valid, 1);
      chk("R6", "retry climbs", retry_cnt, k);
      tick();
    end
  endtask

  task automatic t_full();
    set_halt(1'b1);
    chk("R3", "halted no req", req_valid, 0);
    for (int k = 0; k < 9; k++) push(ids[k] ^ 36'hF_0000_0000);
    chk("R2", "full count", fifo_count, 8);
    chk("R2", "newest even if dropped", newest_evid, ids[8] ^ 36'hF_0000_0000);
    for (int k = 0; k < 8; k++) begin
      force_once();
      exp_rq = exp_rq + 1'b1;
      chk("R4", "drain order", cur_evid, ids[k] ^ 36'hF_0000_0000);
      chk("R5", "drain rqid", rqid, exp_rq);
      chk("R2", "drain count", fifo_count, 7 - k);
    end
    force_once();
    chk("R2", "ninth dropped", cur_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    trig_valid = 0; cfg_halt_we = 0; cfg_halt_d = 0; cfg_ivl_we = 0;
    cfg_en_we = 0; force_adv = 0; rsp_valid = 0;
    trig_evid = '0; rsp_evid = '0; cfg_ivl_d = '0; cfg_en_d = '0; rsp_chan = '0;
    for (int k = 0; k < 9; k++) ids[k] = 36'hA_1234_0000 + 36'(k * 17 + 1);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_fill_halted();
    t_force_halted();
    t_run_match();
    t_disabled();
    t_force_running();
    t_all_disabled();
    t_ivl_zero();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule